// File: doc/BRIEF.md
# Shift, Rotate and Byte-Swap Execution Unit

This unit executes the shift, rotate and byte-swap instruction group of a 16-bit processor. The issue stage presents a 10-bit instruction word, the current value of the selected working register and the present carry and overflow flags, and raises `issue` for one clock. On the next rising edge the unit registers the new register value, the index of the register to write back, the four status flags with one write enable each, and the number of machine cycles the instruction costs.

Eight operations share the group: a byte swap, logical left and right shifts, an arithmetic right shift, two shifts that also report the bits shifted out, and rotates left and right through the carry flag. Each operation has a single-step form and a double-step form. In the double-step rotates the overflow flag is a second link in the chain. Instruction fetch, the register file and the other instruction groups are handled elsewhere.

Top module: `srs_unit`

## Requirements
- R1: An instruction word in the range 0x040 to 0x07F presented with `issue` high gives `done` high on the next rising edge, for one cycle. Bits 5:3 select the operation: 0 swap, 1 logical left shift, 2 rotate left through carry, 3 left shift into carry, 4 logical right shift, 5 arithmetic right shift, 6 rotate right through carry, 7 arithmetic right shift into carry. Bit 2 selects the double-step form, and bits 1:0 appear on `dst_reg`. `done` is low in any cycle that follows a cycle without `issue`.
- R2: An instruction word outside 0x040 to 0x07F never raises `done`.
- R3: `cycles` is 6 for a single-step form and 8 for a double-step form.
- R4: The single swap exchanges the high and low bytes. The double swap copies the low byte into both bytes.
- R5: The logical left shift moves the word left by 1 or 2 and fills with zeros. The logical right shift moves it right and fills with zeros. The arithmetic right shift copies bit 15 into every vacated bit.
- R6: The single rotate left gives {v[14:0], C} and sets C to v[15]. The double rotate left gives {v[13:0], C, O}, sets C to v[15] and sets O to v[14].
- R7: The single rotate right gives {C, v[15:1]} and sets C to v[0]. The double rotate right gives {O, C, v[15:2]}, sets C to v[0] and sets O to v[1].
- R8: The left shift into carry sets C to the original bit 15, and in its double form sets O to the original bit 14. The arithmetic right shift into carry sets C to the original bit 0, and in its double form sets O to the original bit 1. The result words are the same as those of the plain left shift and the arithmetic right shift.
- R9: The sign flag copies result bit 15 after the three left operations (codes 1, 2, 3) and result bit 7 after all the others. Its write enable is always high.
- R10: The zero flag is 1 exactly when the 16-bit result is 0. Its write enable is always high.
- R11: The carry write enable is high only for codes 2, 3, 6 and 7. The overflow write enable is high only for the double forms of those codes. A flag whose enable is low is output with the value it had at the input on the issue cycle.
- R12: While reset is held, and until the first accepted instruction, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | The instruction word and operands are valid this cycle |
| opcode | input | 10 | Instruction word |
| operand | input | 16 | Current value of the selected register |
| c_in | input | 1 | Carry flag before the instruction |
| o_in | input | 1 | Overflow flag before the instruction |
| done | output | 1 | Registered outputs belong to an accepted instruction |
| result | output | 16 | New register value |
| dst_reg | output | 2 | Register to write back |
| s_out | output | 1 | Sign flag value |
| z_out | output | 1 | Zero flag value |
| c_out | output | 1 | Carry flag value |
| o_out | output | 1 | Overflow flag value |
| s_we | output | 1 | Sign flag write enable |
| z_we | output | 1 | Zero flag write enable |
| c_we | output | 1 | Carry flag write enable |
| o_we | output | 1 | Overflow flag write enable |
| cycles | output | 4 | Machine cycles the instruction costs |

## Verification
Every result, flag, enable and cycle count is due on the first rising edge after the cycle in which `issue` is high, and `done` drops again one edge later. The bench drives each instruction on a falling edge and compares all outputs on the next falling edge, so exactly one register stage lies between stimulus and sample. It then lets an idle cycle pass and confirms that `done` is low. The sweep covers all 64 instruction words of the group, a set of edge and patterned operands and all four carry and overflow combinations. Instruction words on both sides of the group's range confirm that no result is reported for them.

// File: rtl/srs_pkg.sv
// Shared types for the shift/rotate/swap unit.
// Assumes the operation field is three bits wide, in the order the decoder uses.
package srs_pkg;
    typedef enum logic [2:0] {
        OP_SWAP = 3'd0,
        OP_SLL  = 3'd1,
        OP_RLC  = 3'd2,
        OP_SLLC = 3'd3,
        OP_SLR  = 3'd4,
        OP_SAR  = 3'd5,
        OP_RRC  = 3'd6,
        OP_SARC = 3'd7
    } srs_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic c;
        logic o;
    } srs_flags_t;
endpackage

// File: rtl/srs_decode.sv
// Instruction decoder for the shift/rotate/swap group.
// Splits the word into the group check, the operation, the step count and the register.
// Assumes the group is identified by the bits above bit 5 matching GROUP_TAG.
module srs_decode
    import srs_pkg::*;
#(
    parameter int OPC_W     = 10,
    parameter int REG_W     = 2,
    parameter int GROUP_TAG = 1
) (
    input  logic [OPC_W-1:0] opcode,
    output logic             legal,
    output srs_op_e          op,
    output logic             dbl,
    output logic [REG_W-1:0] reg_idx
);
    localparam int OP_LSB  = 3;
    localparam int DBL_BIT = 2;
    localparam int TAG_LSB = 6;
    localparam int TAG_W   = OPC_W - TAG_LSB;

    // Split the instruction word into its fields.
    always_comb begin
        legal   = (opcode[OPC_W-1:TAG_LSB] == TAG_W'(GROUP_TAG));
        op      = srs_op_e'(opcode[OP_LSB+2:OP_LSB]);
        dbl     = opcode[DBL_BIT];
        reg_idx = opcode[REG_W-1:0];
    end
endmodule

// File: rtl/srs_datapath.sv
// Combinational datapath: computes the new word, the flag values and the flag enables.
// The double-step forms are computed in one pass, not as two single steps.
// Flags that an operation leaves alone are passed through with their enables low.
module srs_datapath
    import srs_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  srs_op_e           op,
    input  logic              dbl,
    input  logic [WORD_W-1:0] v,
    input  logic              c_in,
    input  logic              o_in,
    output logic [WORD_W-1:0] res,
    output srs_flags_t        flg,
    output srs_flags_t        we
);
    localparam int HALF = WORD_W / 2;
    localparam int MSB  = WORD_W - 1;
    localparam int LSGN = HALF - 1;

    logic left_op;

    // Compute the result word and the carry/overflow side effects of each operation.
    always_comb begin
        res   = v;
        flg.c = c_in;
        flg.o = o_in;
        we.s  = 1'b1;
        we.z  = 1'b1;
        we.c  = 1'b0;
        we.o  = 1'b0;
        case (op)
            OP_SWAP: res = dbl ? {v[HALF-1:0], v[HALF-1:0]} : {v[HALF-1:0], v[MSB:HALF]};
            OP_SLL:  res = dbl ? {v[MSB-2:0], 2'b00} : {v[MSB-1:0], 1'b0};
            OP_SLLC: begin
                res   = dbl ? {v[MSB-2:0], 2'b00} : {v[MSB-1:0], 1'b0};
                we.c  = 1'b1;
                flg.c = v[MSB];
                we.o  = dbl;
                flg.o = dbl ? v[MSB-1] : o_in;
            end
            OP_RLC: begin
                res   = dbl ? {v[MSB-2:0], c_in, o_in} : {v[MSB-1:0], c_in};
                we.c  = 1'b1;
                flg.c = v[MSB];
                we.o  = dbl;
                flg.o = dbl ? v[MSB-1] : o_in;
            end
            OP_SLR:  res = dbl ? {2'b00, v[MSB:2]} : {1'b0, v[MSB:1]};
            OP_SAR:  res = dbl ? {{2{v[MSB]}}, v[MSB:2]} : {v[MSB], v[MSB:1]};
            OP_SARC: begin
                res   = dbl ? {{2{v[MSB]}}, v[MSB:2]} : {v[MSB], v[MSB:1]};
                we.c  = 1'b1;
                flg.c = v[0];
                we.o  = dbl;
                flg.o = dbl ? v[1] : o_in;
            end
            OP_RRC: begin
                res   = dbl ? {o_in, c_in, v[MSB:2]} : {c_in, v[MSB:1]};
                we.c  = 1'b1;
                flg.c = v[0];
                we.o  = dbl;
                flg.o = dbl ? v[1] : o_in;
            end
            default: res = v;
        endcase
    end

    // Sign comes from the top bit for left operations, from the low-byte top bit otherwise.
    always_comb begin
        left_op = (op == OP_SLL) || (op == OP_RLC) || (op == OP_SLLC);
        flg.s   = left_op ? res[MSB] : res[LSGN];
        flg.z   = (res == '0);
    end
endmodule

// File: rtl/srs_unit.sv
// Shift/rotate/swap execution unit, top level.
// Decodes the instruction, runs the combinational datapath and registers all
// outputs on the edge after issue. Synchronous active-low reset clears every output.
// Assumes the issuing stage holds operands stable only during the issue cycle.
module srs_unit
    import srs_pkg::*;
#(
    parameter int OPC_W      = 10,
    parameter int WORD_W     = 16,
    parameter int REG_W      = 2,
    parameter int SINGLE_CYC = 6,
    parameter int DOUBLE_CYC = 8,
    parameter int CYC_W      = $clog2(DOUBLE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OPC_W-1:0]  opcode,
    input  logic [WORD_W-1:0] operand,
    input  logic              c_in,
    input  logic              o_in,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic [REG_W-1:0]  dst_reg,
    output logic              s_out,
    output logic              z_out,
    output logic              c_out,
    output logic              o_out,
    output logic              s_we,
    output logic              z_we,
    output logic              c_we,
    output logic              o_we,
    output logic [CYC_W-1:0]  cycles
);
    localparam int DBL_BIT = 2;

    logic              legal;
    srs_op_e           op;
    logic              dbl;
    logic [REG_W-1:0]  reg_idx;
    logic [WORD_W-1:0] dp_res;
    srs_flags_t        dp_flg;
    srs_flags_t        dp_we;

    srs_decode #(.OPC_W(OPC_W), .REG_W(REG_W), .GROUP_TAG(1)) u_decode (
        .opcode  (opcode),
        .legal   (legal),
        .op      (op),
        .dbl     (dbl),
        .reg_idx (reg_idx)
    );

    srs_datapath #(.WORD_W(WORD_W)) u_datapath (
        .op   (op),
        .dbl  (dbl),
        .v    (operand),
        .c_in (c_in),
        .o_in (o_in),
        .res  (dp_res),
        .flg  (dp_flg),
        .we   (dp_we)
    );

    // Capture the outcome of an accepted instruction; pulse done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            result  <= '0;
            dst_reg <= '0;
            s_out   <= 1'b0;
            z_out   <= 1'b0;
            c_out   <= 1'b0;
            o_out   <= 1'b0;
            s_we    <= 1'b0;
            z_we    <= 1'b0;
            c_we    <= 1'b0;
            o_we    <= 1'b0;
            cycles  <= '0;
        end else begin
            done <= issue && legal;
            if (issue && legal) begin
                result  <= dp_res;
                dst_reg <= reg_idx;
                s_out   <= dp_flg.s;
                z_out   <= dp_flg.z;
                c_out   <= dp_flg.c;
                o_out   <= dp_flg.o;
                s_we    <= dp_we.s;
                z_we    <= dp_we.z;
                c_we    <= dp_we.c;
                o_we    <= dp_we.o;
                cycles  <= dbl ? CYC_W'(DOUBLE_CYC) : CYC_W'(SINGLE_CYC);
            end
        end
    end

    p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        issue && legal |=> done && dst_reg == $past(opcode[REG_W-1:0]));

    p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue && legal) |=> !done);

    p_cost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cycles == ($past(opcode[DBL_BIT]) ? CYC_W'(DOUBLE_CYC) : CYC_W'(SINGLE_CYC)));

    p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && z_out |-> result == '0);

    p_keepc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !c_we |-> c_out == $past(c_in));

    p_keepo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && !o_we |-> o_out == $past(o_in));

    p_ovf_double_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && o_we |-> c_we && cycles == CYC_W'(DOUBLE_CYC));
endmodule

// File: tb/srs_unit_bench.sv
`timescale 1ns/1ps
module srs_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        issue;
    logic [9:0]  opcode;
    logic [15:0] operand;
    logic        c_in, o_in;
    logic        done;
    logic [15:0] result;
    logic [1:0]  dst_reg;
    logic        s_out, z_out, c_out, o_out, s_we, z_we, c_we, o_we;
    logic [3:0]  cycles;

    int checks = 0;
    int bad    = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    srs_unit u_srs_unit (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode), .operand(operand),
        .c_in(c_in), .o_in(o_in), .done(done), .result(result), .dst_reg(dst_reg),
        .s_out(s_out), .z_out(z_out), .c_out(c_out), .o_out(o_out),
        .s_we(s_we), .z_we(z_we), .c_we(c_we), .o_we(o_we), .cycles(cycles)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Arithmetic reference for one instruction of the group.
    task automatic model(input int op, input int v, input int c, input int o,
                         output int r, output int s, output int z, output int cc, output int oo,
                         output int cwe, output int owe, output int cyc, output string tag);
        int kind, dbl, mul;
        kind = (op / 8) % 8;
        dbl  = (op / 4) % 2;
        mul  = dbl ? 4 : 2;
        cc = c; oo = o; cwe = 0; owe = 0;
        r = v;
        case (kind)
            0: begin r = dbl ? (v % 256) * 257 : (v % 256) * 256 + v / 256; tag = "R4"; end
            1: begin r = (v * mul) % 65536; tag = "R5"; end
            2: begin
                r = dbl ? (v * 4) % 65536 + c * 2 + o : (v * 2) % 65536 + c;
                cc = v / 32768; if (dbl != 0) oo = (v / 16384) % 2; tag = "R6";
            end
            3: begin
                r = (v * mul) % 65536; cc = v / 32768;
                if (dbl != 0) oo = (v / 16384) % 2; tag = "R8";
            end
            4: begin r = v / mul; tag = "R5"; end
            5: begin r = v / mul + (v >= 32768 ? (dbl ? 49152 : 32768) : 0); tag = "R5"; end
            6: begin
                r = dbl ? v / 4 + c * 16384 + o * 32768 : v / 2 + c * 32768;
                cc = v % 2; if (dbl != 0) oo = (v / 2) % 2; tag = "R7";
            end
            default: begin
                r = v / mul + (v >= 32768 ? (dbl ? 49152 : 32768) : 0);
                cc = v % 2; if (dbl != 0) oo = (v / 2) % 2; tag = "R8";
            end
        endcase
        if (kind == 2 || kind == 3 || kind == 6 || kind == 7) begin
            cwe = 1; owe = dbl;
        end
        s   = (kind >= 1 && kind <= 3) ? r / 32768 : (r / 128) % 2;
        z   = (r == 0) ? 1 : 0;
        cyc = dbl ? 8 : 6;
    endtask

    function automatic int pick_operand(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'hFFFF;
            2: return 16'h8000;
            3: return 16'h0001;
            4: return 16'h4002;
            5: return 16'h00FF;
            6: return 16'hA5C3;
            default: return (i * 40503 + 12345) % 65536;
        endcase
    endfunction

    task automatic run_one(input int op, input int v, input int c, input int o);
        int r, s, z, cc, oo, cwe, owe, cyc;
        string tag;
        model(op, v, c, o, r, s, z, cc, oo, cwe, owe, cyc, tag);
        @(negedge clk);
        issue = 1'b1; opcode = 10'(op); operand = 16'(v); c_in = 1'(c); o_in = 1'(o);
        @(negedge clk);
        issue = 1'b0; c_in = ~c_in; o_in = ~o_in;
        check("R1", "done", int'(done), 1);
        check("R1", "dst_reg", int'(dst_reg), op % 4);
        check(tag, "result", int'(result), r);
        check("R3", "cycles", int'(cycles), cyc);
        check("R9", "sign", int'(s_out), s);
        check("R9", "sign_we", int'(s_we), 1);
        check("R10", "zero", int'(z_out), z);
        check("R10", "zero_we", int'(z_we), 1);
        check(cwe != 0 ? tag : "R11", "carry", int'(c_out), cc);
        check(owe != 0 ? tag : "R11", "overflow", int'(o_out), oo);
        check("R11", "carry_we", int'(c_we), cwe);
        check("R11", "overflow_we", int'(o_we), owe);
        @(negedge clk);
        check("R1", "done_idle", int'(done), 0);
    endtask

    task automatic run_outside(input int op);
        @(negedge clk);
        issue = 1'b1; opcode = 10'(op); operand = 16'h1234; c_in = 1'b1; o_in = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check("R2", "done_outside", int'(done), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; issue = 1'b0; opcode = '0; operand = '0; c_in = 1'b0; o_in = 1'b0;
        repeat (3) @(negedge clk);
        // R12: reset state of every output
        check("R12", "reset_done", int'(done), 0);
        check("R12", "reset_result", int'(result), 0);
        check("R12", "reset_flags", int'({s_out, z_out, c_out, o_out, s_we, z_we, c_we, o_we}), 0);
        check("R12", "reset_cycles", int'(cycles), 0);
        check("R12", "reset_reg", int'(dst_reg), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12", "idle_done", int'(done), 0);

        for (int op = 'h40; op <= 'h7F; op++)
            for (int i = 0; i < 10; i++)
                for (int f = 0; f < 4; f++)
                    run_one(op, pick_operand(i), f / 2, f % 2);

        // R2: words on both sides of the group range
        run_outside('h03F);
        run_outside('h000);
        run_outside('h080);
        run_outside('h0C5);
        run_outside('h240);
        run_outside('h3FF);

        ended = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule